// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Controller

This block sits beside four counter channels and turns their zero-count request flags into a single active-low interrupt request. It takes part in a serial priority chain through an enable-in input and an enable-out output. When the processor runs an acknowledge cycle, the block answers with an 8-bit vector. The vector holds a programmed base and the 2-bit number of the winning channel. The block then tells that channel's counter to drop its request flag, and it marks the channel as under service.

Inside the block the priority is fixed: channel 0 is the highest and channel 3 the lowest. A channel under service holds off itself and every lower channel, but it never holds off a higher one. The block watches opcode fetches for the two-byte return sequence, the prefix byte ED followed by 4D. When that sequence completes while enable-in is high, the highest-priority channel under service is released. While the processor is in an M1 cycle, the block freezes the request flags it has sampled, so the arbitration cannot change under an acknowledge.

Top module: `irq_chain_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no channel pending or in service, `int_n` is 1, `ieo` equals `iei`, `vec_oe` is 0 and `req_clr` is 0.
- R2: The candidates are the channels whose request and enable are both set. The winner is the lowest-numbered candidate that sits above every channel under service.
- R3: A driven vector is {`vec_base`, channel number, 0}. Channel number 00 is channel 0 and 11 is channel 3. `vec_out` is 0 whenever `vec_oe` is 0.
- R4: `vec_oe` is 1 only during an acknowledge, which is `m1_n`=0 together with `iorq_n`=0. The acknowledge must start with `iei` high and a winner present. The vector is held for the whole acknowledge.
- R5: The request flags are sampled only on clocks where `m1_n` is 1. A change on `ch_req` while `m1_n` is 0 has no effect on `int_n` until `m1_n` returns high.
- R6: The first clock of an answered acknowledge is followed by exactly one cycle of `req_clr`, one-hot on the winner. From that point the winner counts as under service.
- R7: A channel under service keeps `int_n` high against requests from itself and from lower channels. A higher channel can still assert `int_n`.
- R8: `ieo` is 1 only when `iei` is 1, no channel is under service, and no sampled request is pending.
- R9: An opcode fetch is `m1_n`=0, `rd_n`=0 and `iorq_n`=1. After a fetch of ED, a block with only pending requests lets `ieo` follow `iei` until `m1_n` rises.
- R10: A fetch of 4D that comes right after a fetch of ED, with `iei` high, releases only the highest-priority channel under service. A 4D with no ED before it, or with `iei` low, releases nothing.
- R11: A channel whose `ch_ien` bit is 0 is ignored. Its request moves neither `int_n` nor `ieo`.
- R12: `int_n` is 0 exactly when `iei` is 1 and a winner exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_req | input | NUM_CH | Per-channel zero-count request flags |
| ch_ien | input | NUM_CH | Per-channel interrupt enable flags |
| vec_base | input | BASE_W | Programmed upper vector bits |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| fetch_data | input | DATA_W | Data bus byte seen during opcode fetches |
| iei | input | 1 | Chain enable from higher-priority devices |
| int_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Chain enable to lower-priority devices |
| vec_out | output | DATA_W | Vector byte during acknowledge |
| vec_oe | output | 1 | Vector drive enable |
| req_clr | output | NUM_CH | One-cycle request clear pulses to the counters |

## Verification
The bench builds the block with its default values: four channels, an 8-bit data byte and a 5-bit base. These values make every channel code from 00 to 11 reachable, along with service nesting two levels deep. A behavioural model in the bench reproduces freezing, granting and release with plain integers. It is compared with every output on every clock. Directed scenarios drive the following cases:
- nested service and releases in order;
- a channel that is disabled;
- acknowledges and returns with `iei` low;
- a lone 4D;
- the window that opens after an ED fetch.

// File: rtl/irq_chain_pkg.sv
// Shared constants for the interrupt chain controller.
// Assumes an 8-bit opcode bus; the return sequence is prefix then return byte.
package irq_chain_pkg;
    localparam logic [7:0] OP_PREFIX = 8'hED;
    localparam logic [7:0] OP_RETURN = 8'h4D;
endpackage

// File: rtl/irq_prio.sv
// Fixed-priority picker: bit 0 is the highest priority.
// A request wins when no higher bit has an unblocked request and no blocking
// bit is set at or above its own position. Output is one-hot or zero.
module irq_prio #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] blk,
    output logic [NUM_CH-1:0] win
);
    logic [NUM_CH-1:0] blk_up;
    logic [NUM_CH-1:0] ok;
    logic [NUM_CH-1:0] taken_above;

    genvar i;
    generate
        for (i = 0; i < NUM_CH; i++) begin : g_slot
            if (i == 0) begin : g_top
                // Highest slot: blocked only by itself, nothing above it.
                assign blk_up[i]      = blk[i];
                assign taken_above[i] = 1'b0;
            end else begin : g_rest
                // Blocking and wins propagate downward through the chain.
                assign blk_up[i]      = blk_up[i-1] | blk[i];
                assign taken_above[i] = taken_above[i-1] | ok[i-1];
            end
            assign ok[i]  = req[i] & ~blk_up[i];
            assign win[i] = ok[i] & ~taken_above[i];
        end
    endgenerate
endmodule

// File: rtl/irq_ret_decode.sv
// Watches opcode fetches for the two-byte return sequence.
// A fetch is M1 and RD low with IORQ high; the byte is taken on its first clock.
// rel_pulse is combinational on the fetch clock of the second byte; ed_win
// stays set from the clock after a prefix fetch until M1 rises.
module irq_ret_decode
    import irq_chain_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m1_n,
    input  logic              rd_n,
    input  logic              iorq_n,
    input  logic [DATA_W-1:0] fetch_data,
    input  logic              iei,
    output logic              rel_pulse,
    output logic              ed_win
);
    logic fetch_now;
    logic fetch_q;
    logic fetch_start;
    logic prefix_q;
    logic is_prefix;
    logic is_return;

    assign fetch_now   = !m1_n && !rd_n && iorq_n;
    assign fetch_start = fetch_now && !fetch_q;
    assign is_prefix   = (fetch_data == DATA_W'(OP_PREFIX));
    assign is_return   = (fetch_data == DATA_W'(OP_RETURN));
    assign rel_pulse   = fetch_start && is_return && prefix_q && iei;

    // Track fetch edges, the prefix flag and the prefix window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q  <= 1'b0;
            prefix_q <= 1'b0;
            ed_win   <= 1'b0;
        end else begin
            fetch_q <= fetch_now;
            if (fetch_start) begin
                prefix_q <= is_prefix;
            end
            if (m1_n) begin
                ed_win <= 1'b0;
            end else if (fetch_start && is_prefix) begin
                ed_win <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_chain_ctrl.sv
// Vectored interrupt controller for four counter channels in a daisy chain.
// Assumes requests stay set until req_clr; strobes are synchronous to clk.
// Request flags are sampled only while M1 is high; the vector is captured
// on the first clock of an acknowledge and held for the rest of it.
module irq_chain_ctrl #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    localparam int CODE_W = $clog2(NUM_CH),
    localparam int BASE_W = DATA_W - 1 - CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_ien,
    input  logic [BASE_W-1:0] vec_base,
    input  logic              m1_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] fetch_data,
    input  logic              iei,
    output logic              int_n,
    output logic              ieo,
    output logic [DATA_W-1:0] vec_out,
    output logic              vec_oe,
    output logic [NUM_CH-1:0] req_clr
);
    logic [NUM_CH-1:0] req_lat;
    logic [NUM_CH-1:0] srv;
    logic [NUM_CH-1:0] win;
    logic [NUM_CH-1:0] rel_oh;
    logic [NUM_CH-1:0] grant_oh;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] cur_code;
    logic              ack;
    logic              ack_q;
    logic              ack_start;
    logic              live_hit;
    logic              hit_q;
    logic              rel_pulse;
    logic              ed_win;

    function automatic logic [CODE_W-1:0] enc(input logic [NUM_CH-1:0] oh);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (oh[k]) r = r | CODE_W'(k);
        end
        return r;
    endfunction

    irq_prio #(.NUM_CH(NUM_CH)) u_arb (
        .req (req_lat),
        .blk (srv),
        .win (win)
    );

    irq_prio #(.NUM_CH(NUM_CH)) u_relpick (
        .req (srv),
        .blk ({NUM_CH{1'b0}}),
        .win (rel_oh)
    );

    irq_ret_decode #(.DATA_W(DATA_W)) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .m1_n       (m1_n),
        .rd_n       (rd_n),
        .iorq_n     (iorq_n),
        .fetch_data (fetch_data),
        .iei        (iei),
        .rel_pulse  (rel_pulse),
        .ed_win     (ed_win)
    );

    assign ack       = !m1_n && !iorq_n;
    assign ack_start = ack && !ack_q;
    assign live_hit  = iei && (|win);
    assign grant_oh  = (ack_start && live_hit) ? win : '0;

    // Sample enabled requests outside M1; freeze them inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_lat <= '0;
        end else if (m1_n) begin
            req_lat <= ch_req & ch_ien;
        end
    end

    // Acknowledge capture, clear pulses and the under-service set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            hit_q   <= 1'b0;
            code_q  <= '0;
            req_clr <= '0;
            srv     <= '0;
        end else begin
            ack_q   <= ack;
            req_clr <= grant_oh;
            srv     <= (srv | grant_oh) & ~(rel_pulse ? rel_oh : '0);
            if (ack_start) begin
                hit_q  <= live_hit;
                code_q <= enc(win);
            end
        end
    end

    // Chain outputs and the vector drive.
    always_comb begin
        cur_code = ack_start ? enc(win) : code_q;
        vec_oe   = ack && (ack_start ? live_hit : hit_q);
        vec_out  = vec_oe ? {vec_base, cur_code, 1'b0} : '0;
        int_n    = !live_hit;
        ieo      = iei && !(|srv) && (!(|req_lat) || ed_win);
    end
endmodule

// File: rtl/irq_chain_chk.sv
// Property checker for irq_chain_ctrl, attached by bind below.
// Relates the port-level outputs to the bus strobes and to reset.
module irq_chain_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int BASE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m1_n,
    input logic              iorq_n,
    input logic              iei,
    input logic [BASE_W-1:0] vec_base,
    input logic              int_n,
    input logic              ieo,
    input logic              vec_oe,
    input logic [DATA_W-1:0] vec_out,
    input logic [NUM_CH-1:0] req_clr
);
    logic seen_q;
    logic rst_q;

    // Remember whether a clock has passed and the reset level at that clock.
    always_ff @(posedge clk) begin
        seen_q <= 1'b1;
        rst_q  <= rst_n;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        (seen_q === 1'b1 && rst_q === 1'b0) |-> (int_n && !vec_oe && req_clr == '0 && ieo == iei));

    a_r3_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (vec_out[0] == 1'b0 && vec_out[DATA_W-1:DATA_W-BASE_W] == vec_base));

    a_r3_vector_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> vec_out == '0);

    a_r4_drive_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (!m1_n && !iorq_n));

    a_r6_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_clr));

    a_r6_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clr != '0) |=> (req_clr == '0));

    a_r6_clr_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clr != '0) |-> $past(vec_oe));

    a_r8_ieo_needs_iei: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |-> !ieo);

    a_r12_int_needs_iei: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> iei);
endmodule

bind irq_chain_ctrl irq_chain_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .BASE_W (BASE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m1_n     (m1_n),
    .iorq_n   (iorq_n),
    .iei      (iei),
    .vec_base (vec_base),
    .int_n    (int_n),
    .ieo      (ieo),
    .vec_oe   (vec_oe),
    .vec_out  (vec_out),
    .req_clr  (req_clr)
);

// File: tb/sim_irq_chain_ctrl.sv
module sim_irq_chain_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] ch_req, ch_ien;
    logic [4:0] vec_base;
    logic       m1_n, iorq_n, rd_n, iei;
    logic [7:0] fetch_data;
    logic       int_n, ieo, vec_oe;
    logic [7:0] vec_out;
    logic [3:0] req_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    logic [3:0] m_lat, m_srv, m_clr;
    bit m_ackq, m_hitq, m_fq, m_pfx, m_edw;
    int m_code;
    logic [3:0] obs_clr;
    logic [7:0] got_vec;
    logic       got_oe;
    logic [3:0] got_clr;

    irq_chain_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_ien(ch_ien),
        .vec_base(vec_base), .m1_n(m1_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .fetch_data(fetch_data), .iei(iei), .int_n(int_n), .ieo(ieo),
        .vec_out(vec_out), .vec_oe(vec_oe), .req_clr(req_clr)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_win();
        for (int i = 0; i < 4; i++) begin
            if (m_srv[i]) return -1;
            if (m_lat[i]) return i;
        end
        return -1;
    endfunction

    task automatic model_compare();
        int w;
        bit ack, ast, oe_e, ieo_e;
        int code;
        logic [7:0] v_e;
        w     = m_win();
        ack   = !m1_n && !iorq_n;
        ast   = ack && !m_ackq;
        oe_e  = ack && (ast ? (iei && w >= 0) : m_hitq);
        code  = ast ? w : m_code;
        v_e   = oe_e ? {vec_base, 2'(code), 1'b0} : 8'h00;
        ieo_e = iei && (m_srv == 0) && (m_lat == 0 || m_edw);
        chk("R12 int_n", int_n, !(iei && w >= 0));
        chk("R8 ieo", ieo, ieo_e);
        chk("R4 vec_oe", vec_oe, oe_e);
        chk("R3 vec_out", vec_out, v_e);
        chk("R6 req_clr", req_clr, m_clr);
    endtask

    task automatic model_update();
        int w;
        bit ack, ast, fetch, fs;
        logic [3:0] gnt;
        if (!rst_n) begin
            m_lat = 0; m_srv = 0; m_clr = 0; m_ackq = 0; m_hitq = 0;
            m_code = 0; m_fq = 0; m_pfx = 0; m_edw = 0;
            return;
        end
        w     = m_win();
        ack   = !m1_n && !iorq_n;
        ast   = ack && !m_ackq;
        fetch = !m1_n && !rd_n && iorq_n;
        fs    = fetch && !m_fq;
        gnt   = 0;
        if (ast && iei && w >= 0) gnt[w] = 1'b1;
        if (ast) begin
            m_hitq = iei && w >= 0;
            m_code = (w >= 0) ? w : 0;
        end
        m_clr  = gnt;
        m_ackq = ack;
        m_fq   = fetch;
        if (fs && fetch_data == 8'h4D && m_pfx && iei) begin
            for (int i = 0; i < 4; i++) begin
                if (m_srv[i]) begin m_srv[i] = 1'b0; break; end
            end
        end
        m_srv = m_srv | gnt;
        if (fs) m_pfx = (fetch_data == 8'hED);
        if (m1_n) m_edw = 0;
        else if (fs && fetch_data == 8'hED) m_edw = 1;
        if (m1_n) m_lat = ch_req & ch_ien;
    endtask

    task automatic half();
        @(negedge clk); #1;
        obs_clr = req_clr;
        model_compare();
    endtask

    task automatic fin();
        @(posedge clk); #1;
        model_update();
        ch_req = ch_req & ~obs_clr;   // counters drop a cleared request
    endtask

    task automatic cyc();
        half(); fin();
    endtask

    task automatic do_ack();
        m1_n = 0; cyc();
        iorq_n = 0; half();
        got_vec = vec_out; got_oe = vec_oe;
        fin();
        half(); got_clr = obs_clr; fin();
        m1_n = 1; iorq_n = 1; cyc();
    endtask

    task automatic fetch(input logic [7:0] b);
        m1_n = 0; rd_n = 0; fetch_data = b; cyc(); cyc();
        rd_n = 1; m1_n = 1; cyc();
    endtask

    task automatic ret();
        fetch(8'hED); fetch(8'h4D);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ch_req = 0; ch_ien = 0; vec_base = 5'b10110;
        m1_n = 1; iorq_n = 1; rd_n = 1; fetch_data = 0; iei = 1;
        obs_clr = 0;
        m_lat = 0; m_srv = 0; m_clr = 0; m_ackq = 0; m_hitq = 0;
        m_code = 0; m_fq = 0; m_pfx = 0; m_edw = 0;
        cyc(); cyc();
        half();
        chk("R1 int_n", int_n, 1); chk("R1 ieo", ieo, 1);
        chk("R1 vec_oe", vec_oe, 0); chk("R1 req_clr", req_clr, 0);
        fin();
        rst_n = 1; cyc();

        // two pending, channel 1 wins
        ch_ien = 4'hF; ch_req = 4'b0110; cyc();
        half(); chk("R12 pending asserts", int_n, 0); chk("R8 pending holds ieo", ieo, 0); fin();
        do_ack();
        chk("R2 winner ch1", got_vec, 8'hB2);
        chk("R6 clear ch1", got_clr, 4'b0010);
        half(); chk("R7 ch2 blocked", int_n, 1); fin();

        // higher channel preempts
        ch_req[0] = 1; cyc();
        half(); chk("R7 higher not blocked", int_n, 0); fin();
        do_ack();
        chk("R2 winner ch0", got_vec, 8'hB0);

        // nested releases
        ret();
        half(); chk("R10 only ch0 released", int_n, 1); fin();
        ret();
        half(); chk("R10 ch1 released", int_n, 0); fin();

        // freeze during M1
        m1_n = 0; cyc();
        ch_req = 0; cyc();
        half(); chk("R5 frozen", int_n, 0); fin();
        m1_n = 1; cyc();
        half(); chk("R5 resampled", int_n, 1); fin();

        // disabled channel
        ch_ien = 4'b0111; ch_req = 4'b1000; cyc();
        half(); chk("R11 int ignored", int_n, 1); chk("R11 ieo ignored", ieo, 1); fin();
        ch_ien = 4'hF; cyc();
        half(); chk("R11 enabled asserts", int_n, 0); fin();
        do_ack();
        chk("R3 code ch3", got_vec, 8'hB6);
        half(); chk("R8 service holds ieo", ieo, 0); fin();
        ret();
        half(); chk("R10 ch3 released", ieo, 1); fin();

        // prefix window with only a pending request
        ch_req = 4'b0100; cyc();
        half(); chk("R8 pending low", ieo, 0); fin();
        m1_n = 0; rd_n = 0; fetch_data = 8'hED; cyc();
        half(); chk("R9 window opens", ieo, 1); fin();
        rd_n = 1; m1_n = 1; cyc();
        half(); chk("R9 window closes", ieo, 0); fin();

        // no release with iei low or lone return byte
        do_ack();
        chk("R2 winner ch2", got_vec, 8'hB4);
        iei = 0; ret(); iei = 1; cyc();
        half(); chk("R10 iei low keeps service", ieo, 0); fin();
        fetch(8'h4D);
        half(); chk("R10 lone 4D keeps service", ieo, 0); fin();
        ret();
        half(); chk("R10 released", ieo, 1); fin();

        // acknowledge ignored with iei low
        iei = 0; ch_req = 4'b0001; cyc();
        half(); chk("R12 iei low", int_n, 1); fin();
        do_ack();
        chk("R4 no drive iei low", got_oe, 0);
        iei = 1; cyc();
        do_ack();
        chk("R4 drive", got_oe, 1);
        chk("R2 winner ch0 again", got_vec, 8'hB0);
        ret();
        cyc(); cyc();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule